// File: doc/BRIEF.md
# Event Buffer Assembler and Packet Sender

This block takes in one 128-bit pattern buffer at a time and checks its integrity with a ones-complement checksum. It then extends the buffer to a 192-bit event buffer. The extension carries a 32-bit timestamp, a 16-bit application command word, an 8-bit set of fault bits and a checksum-error bit. The fault bits are collected in the interval before the buffer is frozen. When the event buffer is complete, the block raises a ready flag and holds it. A downstream consumer answers with a take strobe. The frozen buffer then goes out as twelve back-to-back 16-bit packets on the link clock, and a done pulse closes the burst.

Only one buffer is in flight at a time. A pattern buffer that arrives while the previous one is still being checked, waiting to be taken or being sent is dropped, and the block reports it with an overrun pulse.

Top module: `evbuf_packer`

## Requirements
- R1: A `pat_valid` pulse while the block is idle captures `pat_data`. `ready_flag` is 0 in the cycle after capture and 1 from the second cycle after capture.
- R2: The pattern is treated as eight 16-bit words, with word 0 at bits 127:112 and word 7 at bits 15:0. The checksum is the 16-bit end-around-carry sum of words 0 to 6. If it differs from word 7, the checksum-error bit is 1; otherwise it is 0.
- R3: The event buffer layout is: bits 191:64 pattern, bits 63:32 timestamp, bits 31:16 command word, bits 15:8 fault bits, bits 7:1 zero, bit 0 checksum error.
- R4: `tstamp` and `app_cmd` are sampled in the capture cycle. Later changes to them do not reach the event buffer.
- R5: The fault field is the OR of every `fault_in` value seen from the cycle after the previous take up to the cycle before this take. A fault seen in the take cycle goes into the next buffer.
- R6: `ready_flag` stays 1 until `take` is seen with it. `take` while `ready_flag` is 0 has no effect. No packet is sent while `ready_flag` is 1.
- R7: The cycle after a take starts twelve consecutive packets on `pkt_data` with `pkt_valid` high, most significant 16-bit word first. `pkt_start` is high on the first packet only.
- R8: `done_flag` is high for exactly one cycle, in the cycle after the twelfth packet.
- R9: `pat_valid` while a buffer is being checked, held ready or sent raises `overrun_flag` for one cycle in the next cycle. That buffer is dropped, and the buffer in flight goes out unchanged.
- R10: After a synchronous active-low reset, all outputs are 0 and any buffer in flight is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pat_valid | input | 1 | Pattern buffer strobe |
| pat_data | input | 128 | Pattern buffer contents |
| tstamp | input | 32 | Free-running timestamp value |
| app_cmd | input | 16 | Application command word |
| fault_in | input | 8 | Fault indicator bits, one cycle each |
| take | input | 1 | Consumer accepts the ready buffer |
| pkt_data | output | 16 | Packet word |
| pkt_valid | output | 1 | Packet word valid |
| pkt_start | output | 1 | First packet of a burst |
| ready_flag | output | 1 | Assembled buffer waiting for take |
| done_flag | output | 1 | Burst finished pulse |
| overrun_flag | output | 1 | Incoming buffer dropped pulse |

## Verification
The assertions watch the packet framing on every cycle: start marks a valid packet, bursts are contiguous, a burst never exceeds twelve packets, and done follows the last packet. They also check that ready holds until taken, that ready and sending never overlap, that overrun has a preceding strobe, and that ready rises two cycles after a strobe. Only the bench scenarios can show that the content is right. That covers the packet word values and their order, the checksum verdict under carry-heavy patterns, the fault bits that cross the take boundary into the next buffer, and the fact that dropped buffers leave the burst in flight unchanged.

// File: rtl/evbuf_pkg.sv
// Package: shared widths and the controller state type for the event
// buffer packer. Assumes the event buffer is a whole number of packets.
package evbuf_pkg;
    localparam int PAT_W  = 128;
    localparam int WORD_W = 16;
    localparam int TS_W   = 32;
    localparam int CMD_W  = 16;
    localparam int FLT_W  = 8;
    localparam int EVB_W  = 192;
    localparam int RSV_W  = EVB_W - PAT_W - TS_W - CMD_W - FLT_W - 1;
    localparam int NPKT   = EVB_W / WORD_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_HOLD  = 2'd2,
        ST_SEND  = 2'd3
    } pk_state_t;
endpackage

// File: rtl/evbuf_csum.sv
// Module: ones-complement checksum verdict over a pattern buffer.
// The sum of all words but the last (word 0 at the top bits) is folded with
// end-around carry and compared with the last word. Purely combinational;
// assumes PAT_W is a multiple of WORD_W and holds at least two words.
module evbuf_csum #(
    parameter int PAT_W  = 128,
    parameter int WORD_W = 16
) (
    input  logic [PAT_W-1:0] data,
    output logic             mismatch
);
    localparam int NW = PAT_W / WORD_W;

    logic [WORD_W-1:0] acc [NW];
    logic [WORD_W-1:0] last_word;

    assign acc[0]    = data[PAT_W-1 -: WORD_W];
    assign last_word = data[WORD_W-1:0];

    // Chain of end-around-carry adders, one stage per summed word.
    for (genvar i = 1; i < NW - 1; i++) begin : g_sum
        logic [WORD_W:0] raw;
        assign raw    = {1'b0, acc[i-1]} + {1'b0, data[PAT_W-1-i*WORD_W -: WORD_W]};
        assign acc[i] = raw[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, raw[WORD_W]};
    end

    // Verdict: the folded sum must equal the transmitted check word.
    assign mismatch = (acc[NW-2] != last_word);
endmodule

// File: rtl/evbuf_fault_acc.sv
// Module: sticky fault collector. Every cycle ORs the fault inputs into the
// window; on a clear cycle the window restarts with that cycle's inputs only,
// so nothing arriving during packing is lost. Synchronous active-low reset.
module evbuf_fault_acc #(
    parameter int FLT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [FLT_W-1:0] fault_in,
    output logic [FLT_W-1:0] window
);
    // Window register: accumulate, or restart on a pack cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       window <= '0;
        else if (restart) window <= fault_in;
        else              window <= window | fault_in;
    end
endmodule

// File: rtl/evbuf_serializer.sv
// Module: sends a loaded buffer as back-to-back words, most significant
// word first, flags the first word, and pulses done after the last one.
// Assumes load only arrives while idle. Synchronous active-low reset.
module evbuf_serializer #(
    parameter int BUF_W  = 192,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BUF_W-1:0]  load_data,
    output logic [WORD_W-1:0] word,
    output logic              word_valid,
    output logic              word_first,
    output logic              finishing,
    output logic              done
);
    localparam int NPKT = BUF_W / WORD_W;
    localparam int CW   = $clog2(NPKT + 1);

    logic [BUF_W-1:0] shreg;
    logic [CW-1:0]    idx;
    logic             active;

    assign word       = shreg[BUF_W-1 -: WORD_W];
    assign word_valid = active;
    assign word_first = active && (idx == '0);
    assign finishing  = active && (idx == CW'(NPKT - 1));

    // Shift register and word index for the burst in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            idx    <= '0;
            active <= 1'b0;
        end else if (load) begin
            shreg  <= load_data;
            idx    <= '0;
            active <= 1'b1;
        end else if (active) begin
            shreg  <= {shreg[BUF_W-WORD_W-1:0], {WORD_W{1'b0}}};
            idx    <= idx + 1'b1;
            active <= !finishing;
        end
    end

    // One-cycle completion pulse after the final word.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= finishing;
    end
endmodule

// File: rtl/evbuf_packer.sv
// Module: event buffer assembler and packet sender (top).
// Captures a pattern buffer with its timestamp and command word, judges the
// checksum one cycle later, holds the assembled buffer ready until taken,
// merges the fault window at take time and streams the result as packets.
// Assumes one buffer in flight; extra strobes are dropped and reported.
module evbuf_packer
    import evbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pat_valid,
    input  logic [PAT_W-1:0]  pat_data,
    input  logic [TS_W-1:0]   tstamp,
    input  logic [CMD_W-1:0]  app_cmd,
    input  logic [FLT_W-1:0]  fault_in,
    input  logic              take,
    output logic [WORD_W-1:0] pkt_data,
    output logic              pkt_valid,
    output logic              pkt_start,
    output logic              ready_flag,
    output logic              done_flag,
    output logic              overrun_flag
);
    pk_state_t         state;
    logic [PAT_W-1:0]  pat_q;
    logic [TS_W-1:0]   ts_q;
    logic [CMD_W-1:0]  cmd_q;
    logic              err_q;
    logic              csum_bad;
    logic [FLT_W-1:0]  flt_window;
    logic              accept;
    logic              pack;
    logic              ser_finishing;
    logic [EVB_W-1:0]  evbuf;

    assign accept     = pat_valid && (state == ST_IDLE);
    assign pack       = take && (state == ST_HOLD);
    assign ready_flag = (state == ST_HOLD);
    assign evbuf      = {pat_q, ts_q, cmd_q, flt_window, {RSV_W{1'b0}}, err_q};

    evbuf_csum #(.PAT_W(PAT_W), .WORD_W(WORD_W)) u_csum (
        .data     (pat_q),
        .mismatch (csum_bad)
    );

    evbuf_fault_acc #(.FLT_W(FLT_W)) u_flt (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (pack),
        .fault_in (fault_in),
        .window   (flt_window)
    );

    evbuf_serializer #(.BUF_W(EVB_W), .WORD_W(WORD_W)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (pack),
        .load_data  (evbuf),
        .word       (pkt_data),
        .word_valid (pkt_valid),
        .word_first (pkt_start),
        .finishing  (ser_finishing),
        .done       (done_flag)
    );

    // Controller: idle -> check -> hold (ready) -> send -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (pat_valid)     state <= ST_CHECK;
                ST_CHECK:                    state <= ST_HOLD;
                ST_HOLD:  if (take)          state <= ST_SEND;
                ST_SEND:  if (ser_finishing) state <= ST_IDLE;
                default:                     state <= ST_IDLE;
            endcase
        end
    end

    // Capture registers: pattern, timestamp and command at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_q <= '0;
            ts_q  <= '0;
            cmd_q <= '0;
        end else if (accept) begin
            pat_q <= pat_data;
            ts_q  <= tstamp;
            cmd_q <= app_cmd;
        end
    end

    // Checksum verdict register, set in the check cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                 err_q <= 1'b0;
        else if (state == ST_CHECK) err_q <= csum_bad;
    end

    // Overrun pulse for any strobe that arrives while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) overrun_flag <= 1'b0;
        else        overrun_flag <= pat_valid && (state != ST_IDLE);
    end
endmodule

// File: rtl/evbuf_packer_chk.sv
// Module: protocol checker for evbuf_packer, attached by bind.
// Counts packets of the current burst to bound its length.
module evbuf_packer_chk #(
    parameter int NPKT = 12
) (
    input logic clk,
    input logic rst_n,
    input logic pat_valid,
    input logic take,
    input logic pkt_valid,
    input logic pkt_start,
    input logic ready_flag,
    input logic done_flag,
    input logic overrun_flag
);
    localparam int CW = $clog2(NPKT + 1);
    logic [CW-1:0] seen;

    // Packets seen so far in the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n)         seen <= '0;
        else if (pkt_start) seen <= CW'(1);
        else if (pkt_valid) seen <= seen + 1'b1;
    end

    p_start_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_start |-> pkt_valid);
    p_burst_contig_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_start) |-> $past(pkt_valid));
    p_burst_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_start) |-> (seen < CW'(NPKT)));
    p_done_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_flag |-> ($past(pkt_valid) && !pkt_valid && seen == CW'(NPKT)));
    p_ready_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_flag && !take) |=> ready_flag);
    p_ready_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready_flag |-> !pkt_valid);
    p_overrun_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_flag |-> $past(pat_valid));
    p_ready_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_flag) |-> $past(pat_valid, 2));
endmodule

bind evbuf_packer evbuf_packer_chk #(.NPKT(evbuf_pkg::NPKT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pat_valid    (pat_valid),
    .take         (take),
    .pkt_valid    (pkt_valid),
    .pkt_start    (pkt_start),
    .ready_flag   (ready_flag),
    .done_flag    (done_flag),
    .overrun_flag (overrun_flag)
);

// File: tb/tb_evbuf_packer.sv
// Bench: vector table for the main flow, then directed corner tests.
module tb_evbuf_packer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pat_valid = 1'b0;
    logic [127:0] pat_data = '0;
    logic [31:0]  tstamp = '0;
    logic [15:0]  app_cmd = '0;
    logic [7:0]   fault_in = '0;
    logic         take = 1'b0;
    logic [15:0]  pkt_data;
    logic         pkt_valid, pkt_start, ready_flag, done_flag, overrun_flag;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] carry = '0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    evbuf_packer dut (
        .clk(clk), .rst_n(rst_n), .pat_valid(pat_valid), .pat_data(pat_data),
        .tstamp(tstamp), .app_cmd(app_cmd), .fault_in(fault_in), .take(take),
        .pkt_data(pkt_data), .pkt_valid(pkt_valid), .pkt_start(pkt_start),
        .ready_flag(ready_flag), .done_flag(done_flag), .overrun_flag(overrun_flag)
    );

    // Entry: pattern(128) timestamp(32) command(16) faults(8) checksum-good(1)
    localparam logic [184:0] VEC [4] = '{
        {128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 32'hDEAD_BEEF, 16'hA55A, 8'h05, 1'b1},
        {128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_0000, 32'h0000_0001, 16'hFFFF, 8'h00, 1'b1},
        {128'h1111_2222_3333_4444_5555_6666_7777_0000, 32'h8000_0000, 16'h0001, 8'hF0, 1'b0},
        {128'h0,                                       32'hFFFF_FFFF, 16'h0000, 8'h80, 1'b0}
    };

    function automatic logic [15:0] ocsum(input logic [127:0] p);
        logic [16:0] s = '0;
        for (int i = 0; i < 7; i++) begin
            s = {1'b0, s[15:0]} + {1'b0, p[127-16*i -: 16]};
            s = {1'b0, s[15:0]} + {16'h0, s[16]};
        end
        return s[15:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [191:0] act,
                       input logic [191:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs one buffer: capture, two fault cycles, a wait, take, burst, done.
    task automatic run_buf(input logic [127:0] pat, input logic [31:0] ts,
                           input logic [15:0] cmd, input logic [7:0] fa,
                           input logic [7:0] fb, input logic [7:0] ftake,
                           input bit ovr_hold, input bit ovr_send);
        logic [191:0] exp;
        logic err;
        err = (ocsum(pat) != pat[15:0]);
        exp = {pat, ts, cmd, carry | fa | fb, 7'b0, err};
        @(negedge clk);
        pat_valid = 1'b1; pat_data = pat; tstamp = ts; app_cmd = cmd;
        @(negedge clk);
        pat_valid = 1'b0; tstamp = ~ts; app_cmd = ~cmd; fault_in = fa;
        chk(ready_flag == 1'b0, "R1 ready low after capture", {191'b0, ready_flag}, 192'd0);
        @(negedge clk);
        chk(ready_flag == 1'b1, "R1 ready high", {191'b0, ready_flag}, 192'd1);
        fault_in = fb;
        if (ovr_hold) begin pat_valid = 1'b1; pat_data = ~pat; end
        @(negedge clk);
        pat_valid = 1'b0;
        chk(ready_flag == 1'b1 && pkt_valid == 1'b0, "R6 ready held, no packets",
            {190'b0, ready_flag, pkt_valid}, 192'd2);
        if (ovr_hold)
            chk(overrun_flag == 1'b1, "R9 overrun while ready", {191'b0, overrun_flag}, 192'd1);
        take = 1'b1; fault_in = ftake;
        @(negedge clk);
        take = 1'b0; fault_in = '0;
        carry = ftake;
        for (int k = 0; k < 12; k++) begin
            chk(pkt_valid && (pkt_start == (k == 0)) && pkt_data == exp[191-16*k -: 16],
                "R7 R3 R4 R5 packet word", {174'b0, pkt_valid, pkt_start, pkt_data},
                {174'b0, 1'b1, (k == 0), exp[191-16*k -: 16]});
            if (k == 11) chk(pkt_data[0] == err, "R2 checksum bit", {191'b0, pkt_data[0]},
                             {191'b0, err});
            if (k == 5 && ovr_send) begin pat_valid = 1'b1; pat_data = ~pat; end
            if (k == 6 && ovr_send) begin
                pat_valid = 1'b0;
                chk(overrun_flag == 1'b1, "R9 overrun while sending",
                    {191'b0, overrun_flag}, 192'd1);
            end
            @(negedge clk);
        end
        chk(done_flag && !pkt_valid, "R8 done after last packet",
            {190'b0, done_flag, pkt_valid}, 192'd2);
        @(negedge clk);
        chk(!done_flag && !ready_flag && !overrun_flag, "R8 R9 done single cycle, nothing pending",
            {189'b0, done_flag, ready_flag, overrun_flag}, 192'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({pkt_valid, pkt_start, ready_flag, done_flag, overrun_flag, pkt_data} == '0,
            "R10 outputs in reset", {171'b0, pkt_valid, pkt_start, ready_flag, done_flag,
            overrun_flag, pkt_data}, 192'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: checksum good and bad, carry-heavy sums, several layouts.
        foreach (VEC[i]) begin
            logic [127:0] p;
            p = VEC[i][184:57];
            p[15:0] = VEC[i][0] ? ocsum(p) : (ocsum(p) ^ 16'h0001);
            run_buf(p, VEC[i][56:25], VEC[i][24:9], VEC[i][8:1], 8'h00, 8'h00, 1'b0, 1'b0);
        end

        // R6: take while idle is ignored.
        take = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(!pkt_valid && !ready_flag, "R6 take ignored when idle",
            {190'b0, pkt_valid, ready_flag}, 192'd0);
        take = 1'b0;

        // R5: sticky OR over two cycles; take-cycle fault carried to next buffer.
        run_buf(128'hCAFE_0000_1234_5678_9ABC_DEF0_0F0F_0000, 32'h1234_5678, 16'h0F0F,
                8'h01, 8'h04, 8'h81, 1'b0, 1'b0);
        run_buf(128'h0000_0000_0000_0000_0000_0000_0001_0001, 32'h0, 16'h0,
                8'h00, 8'h00, 8'h00, 1'b0, 1'b0);

        // R9: drops while ready and while sending leave the burst intact.
        run_buf(128'h5A5A_A5A5_0000_FFFF_1234_4321_8888_0000, 32'hABCD_0123, 16'h7E7E,
                8'h10, 8'h00, 8'h00, 1'b1, 1'b1);

        // R10: reset while a buffer is held ready discards it.
        @(negedge clk); pat_valid = 1'b1; pat_data = 128'h1;
        @(negedge clk); pat_valid = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk(!ready_flag && !pkt_valid, "R10 held buffer discarded by reset",
            {190'b0, ready_flag, pkt_valid}, 192'd0);
        take = 1'b1;
        @(negedge clk); take = 1'b0;
        @(negedge clk);
        chk(!pkt_valid, "R10 no burst after reset", {191'b0, pkt_valid}, 192'd0);

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule